// File: doc/BRIEF.md
# Soft Mute Gain Ramp with Stuck-Data Guard

This block sits in the sample path of a six-channel (three stereo pairs) audio output. Every frame strobe it takes one signed sample per channel, scales all of them by a shared gain and registers the result. When a mute is requested, the gain walks down one level per frame until it reaches zero. When the request is withdrawn, the gain walks back up to unity. Because the ramp is counted in frames, its length in time follows the sampling rate.

Alongside the gain path, a guard watches the incoming frames. It raises a mute flag for an external analog mute circuit in three cases: every channel has sat at all zeros or all ones for longer than a configurable number of frames, a clock-fault indication is present, or the power-up interval has not yet ended.

A single bidirectional pin carries either the mute request into the block or the mute flag out of it. A static direction input chooses which role the pin plays.

Top module: `soft_mute_guard`

## Requirements
- R1: After reset the gain is unity (256), all scaled outputs are zero, the stuck counter is cleared, and with no fault inputs the mute flag is low.
- R2: With the effective mute request at 0 and the gain at unity, each output equals its input sample exactly, registered one clock after the frame strobe.
- R3: While the effective request is 1, each strobe outputs floor(sample × g / 256), using the gain g held before that strobe, and then lowers g by one. The result is the arithmetic right shift by 8 of the signed product.
- R4: Once g reaches zero, all outputs are zero from the following strobe on, and the gain stays at zero while the request holds.
- R5: While the effective request is 0, g rises by one per strobe up to 256. A reversal in the middle of a ramp continues from the current level, with no jump.
- R6: A frame is "flat" when every channel word is all zeros or all ones. After more than STUCK_LIMIT consecutive flat frames the mute flag goes high: it is low after exactly STUCK_LIMIT of them and high right after the next one. The counter then saturates and the flag stays high.
- R7: Any frame in which some channel is neither all zeros nor all ones clears the counter. With no other cause present, the flag is low right after that strobe.
- R8: The clock-fault input or the power-up-pending input drives the mute flag high in the same cycle, independent of the data.
- R9: The direction input selects the pin role. At 0 the pin is a request input and the output enable is low. At 1 the output enable is high and the pin input is ignored, so the gain rises or holds at unity as if no mute were requested.
- R10: All channels share one gain, and outputs and gain change only on a frame strobe. Without a strobe they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle frame strobe |
| smp_in | input | NUM_PAIRS*2*SAMPLE_W | Signed input samples, channel 0 in the low bits |
| mute_pin_in | input | 1 | Value sensed on the mute pin (request, active high) |
| pin_dir | input | 1 | Pin role: 0 request input, 1 flag output |
| clk_fault | input | 1 | Clock out-of-specification indication |
| pwr_pending | input | 1 | Power-up interval not yet complete |
| smp_out | output | NUM_PAIRS*2*SAMPLE_W | Scaled samples, registered on the strobe |
| mute_flag | output | 1 | External mute request flag |
| mute_pin_oe | output | 1 | Drive enable for the mute pin |

## Verification
The hardest state to reach is the boundary of the stuck detector. It needs more than eight thousand back-to-back flat frames with no interruption, followed by one ordinary frame. The bench first clears the counter with a busy frame. It then issues exactly STUCK_LIMIT strobes that mix all-zero and all-one words across the channels and confirms the flag is still low. One more strobe must raise it, further strobes must leave it saturated high, and a single frame with one ordinary word must drop it. A second subtle state is a ramp reversed midway, including a reversal caused by switching the pin to output mode while the request is still high. This is reached by interleaving request changes with an arithmetic gain model kept in the bench.

// File: rtl/smg_pkg.sv
package smg_pkg;
   typedef enum logic {
      PIN_AS_REQUEST = 1'b0,
      PIN_AS_FLAG    = 1'b1
   } pin_dir_e;
endpackage

// File: rtl/smg_gain_ramp.sv
module smg_gain_ramp #(
   parameter int RAMP_SHIFT = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic                  mute_req,
   output logic [RAMP_SHIFT:0]   gain
);
   localparam int GW = RAMP_SHIFT + 1;
   localparam logic [GW-1:0] UNITY = GW'(1) << RAMP_SHIFT;

   initial begin
      assert (RAMP_SHIFT >= 2 && RAMP_SHIFT <= 12)
         else $error("smg_gain_ramp: RAMP_SHIFT out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain <= UNITY;
      end else if (step) begin
         if (mute_req && gain != '0)
            gain <= gain - 1'b1;
         else if (!mute_req && gain != UNITY)
            gain <= gain + 1'b1;
      end
   end

   AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      gain <= UNITY); // R5
   AST_GAIN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      step && mute_req && gain != '0 |=> gain == $past(gain) - 1'b1); // R3
   AST_GAIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      step && mute_req && gain == '0 |=> gain == '0); // R4
   AST_GAIN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      step && !mute_req && gain != UNITY |=> gain == $past(gain) + 1'b1); // R5
   AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(gain)); // R10
endmodule

// File: rtl/smg_chan_scale.sv
module smg_chan_scale #(
   parameter int SAMPLE_W   = 24,
   parameter int RAMP_SHIFT = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [SAMPLE_W-1:0]   sample_in,
   input  logic [RAMP_SHIFT:0]   gain,
   output logic [SAMPLE_W-1:0]   sample_out
);
   localparam int GW = RAMP_SHIFT + 1;
   localparam int PW = SAMPLE_W + GW + 1;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;

   assign prod    = $signed(sample_in) * $signed({1'b0, gain});
   assign shifted = prod >>> RAMP_SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sample_out <= '0;
      else if (load)
         sample_out <= shifted[SAMPLE_W-1:0];
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> shifted == PW'($signed(shifted[SAMPLE_W-1:0]))); // R3
   AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
      load && gain == '0 |=> sample_out == '0); // R4
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(sample_out)); // R10
endmodule

// File: rtl/smg_stuck_detect.sv
module smg_stuck_detect #(
   parameter int NCH         = 6,
   parameter int SAMPLE_W    = 24,
   parameter int STUCK_LIMIT = 8192
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_valid,
   input  logic [NCH*SAMPLE_W-1:0]  frame_data,
   output logic                     stuck
);
   localparam int CNT_W = $clog2(STUCK_LIMIT + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STUCK_LIMIT + 1);

   initial begin
      assert (STUCK_LIMIT >= 1) else $error("smg_stuck_detect: STUCK_LIMIT must be positive");
   end

   logic [NCH-1:0]   word_flat;
   logic             frame_flat;
   logic [CNT_W-1:0] run_cnt;

   for (genvar c = 0; c < NCH; c++) begin : g_flat
      logic [SAMPLE_W-1:0] w;
      assign w            = frame_data[c*SAMPLE_W +: SAMPLE_W];
      assign word_flat[c] = (&w) | ~(|w);
   end

   assign frame_flat = &word_flat;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (frame_valid) begin
         if (!frame_flat)
            run_cnt <= '0;
         else if (run_cnt != CNT_MAX)
            run_cnt <= run_cnt + 1'b1;
      end
   end

   assign stuck = (run_cnt == CNT_MAX);

   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CNT_MAX); // R6
   AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid && frame_flat && run_cnt != CNT_MAX |=> run_cnt == $past(run_cnt) + 1'b1); // R6
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid && !frame_flat |=> !stuck && run_cnt == '0); // R7
endmodule

// File: rtl/soft_mute_guard.sv
module soft_mute_guard
   import smg_pkg::*;
#(
   parameter int NUM_PAIRS   = 3,
   parameter int SAMPLE_W    = 24,
   parameter int RAMP_SHIFT  = 8,
   parameter int STUCK_LIMIT = 8192
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              smp_valid,
   input  logic [NUM_PAIRS*2*SAMPLE_W-1:0]   smp_in,
   input  logic                              mute_pin_in,
   input  logic                              pin_dir,
   input  logic                              clk_fault,
   input  logic                              pwr_pending,
   output logic [NUM_PAIRS*2*SAMPLE_W-1:0]   smp_out,
   output logic                              mute_flag,
   output logic                              mute_pin_oe
);
   localparam int NCH = 2 * NUM_PAIRS;
   localparam int GW  = RAMP_SHIFT + 1;

   initial begin
      assert (NUM_PAIRS >= 1) else $error("soft_mute_guard: NUM_PAIRS must be positive");
      assert (SAMPLE_W >= 4)  else $error("soft_mute_guard: SAMPLE_W too small");
   end

   pin_dir_e         dir;
   logic             mute_req;
   logic [GW-1:0]    gain;
   logic             data_stuck;

   assign dir         = pin_dir_e'(pin_dir);
   assign mute_req    = (dir == PIN_AS_REQUEST) && mute_pin_in;
   assign mute_pin_oe = (dir == PIN_AS_FLAG);

   smg_gain_ramp #(.RAMP_SHIFT(RAMP_SHIFT)) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (smp_valid),
      .mute_req (mute_req),
      .gain     (gain)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      smg_chan_scale #(.SAMPLE_W(SAMPLE_W), .RAMP_SHIFT(RAMP_SHIFT)) u_scale (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (smp_valid),
         .sample_in  (smp_in[c*SAMPLE_W +: SAMPLE_W]),
         .gain       (gain),
         .sample_out (smp_out[c*SAMPLE_W +: SAMPLE_W])
      );
   end

   smg_stuck_detect #(.NCH(NCH), .SAMPLE_W(SAMPLE_W), .STUCK_LIMIT(STUCK_LIMIT)) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_valid (smp_valid),
      .frame_data  (smp_in),
      .stuck       (data_stuck)
   );

   assign mute_flag = data_stuck | clk_fault | pwr_pending;

   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_fault || pwr_pending) |-> mute_flag); // R8
   AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      pin_dir && smp_valid |=> gain >= $past(gain)); // R9
endmodule

// File: tb/soft_mute_guard_bench.sv
module soft_mute_guard_bench;
   localparam int W     = 24;
   localparam int NCH   = 6;
   localparam int LIMIT = 8192;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_valid = 1'b0;
   logic [NCH*W-1:0]  smp_in = '0;
   logic              mute_pin_in = 1'b0;
   logic              pin_dir = 1'b0;
   logic              clk_fault = 1'b0;
   logic              pwr_pending = 1'b0;
   logic [NCH*W-1:0]  smp_out;
   logic              mute_flag;
   logic              mute_pin_oe;

   int n_checks = 0;
   int n_fail   = 0;
   int g        = 256;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   soft_mute_guard u_soft_mute_guard (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
      .mute_pin_in(mute_pin_in), .pin_dir(pin_dir), .clk_fault(clk_fault),
      .pwr_pending(pwr_pending), .smp_out(smp_out), .mute_flag(mute_flag),
      .mute_pin_oe(mute_pin_oe)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] gen(input int k, input int c);
      logic [31:0] h;
      logic [W-1:0] v;
      h = 32'(k) * 32'd2654435761 + 32'(c) * 32'd40503 + 32'd977;
      v = h[W+3:4];
      if (k % 11 == 0) v = 24'h7FFFFF;
      if (k % 13 == c) v = 24'h800000;
      if (c == 0 && ((&v) || ~(|v))) v = 24'h000001;
      return v;
   endfunction

   function automatic logic [NCH*W-1:0] busy_frame(input int k);
      logic [NCH*W-1:0] f;
      for (int c = 0; c < NCH; c++) f[c*W +: W] = gen(k, c);
      return f;
   endfunction

   task automatic strobe(input logic [NCH*W-1:0] data, input bit eff_req, input string req);
      @(negedge clk);
      smp_in    = data;
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         longint xs, e;
         logic [W-1:0] expv;
         xs   = longint'($signed(data[c*W +: W]));
         e    = (xs * longint'(g)) >>> 8;
         expv = e[W-1:0];
         chk(smp_out[c*W +: W] == expv, req,
             longint'($signed(smp_out[c*W +: W])), longint'($signed(expv)));
      end
      if (eff_req && g > 0) g--;
      else if (!eff_req && g < 256) g++;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [NCH*W-1:0] hold_ref;
      logic [NCH*W-1:0] flat_f;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(smp_out == '0, "R1", longint'(smp_out[W-1:0]), 0);
      chk(mute_flag == 1'b0, "R1", mute_flag, 0);
      chk(mute_pin_oe == 1'b0, "R9", mute_pin_oe, 0);
      rst_n = 1'b1;

      // R2: unity pass-through
      for (int k = 1; k <= 16; k++) strobe(busy_frame(k), 1'b0, "R2");

      // R3, R4: full ramp down and beyond
      mute_pin_in = 1'b1;
      for (int k = 0; k < 262; k++) strobe(busy_frame(100 + k), 1'b1, k < 256 ? "R3" : "R4");
      chk(g == 0, "R4", g, 0);
      for (int k = 0; k < 4; k++) strobe(busy_frame(400 + k), 1'b1, "R4");

      // R5: ramp up, reversal midway, back to unity
      mute_pin_in = 1'b0;
      for (int k = 0; k < 100; k++) strobe(busy_frame(500 + k), 1'b0, "R5");
      mute_pin_in = 1'b1;
      for (int k = 0; k < 30; k++) strobe(busy_frame(600 + k), 1'b1, "R5");
      mute_pin_in = 1'b0;
      for (int k = 0; k < 200; k++) strobe(busy_frame(700 + k), 1'b0, "R5");

      // R10: outputs hold without a strobe
      hold_ref = smp_out;
      @(negedge clk);
      smp_in = busy_frame(999);
      repeat (5) @(negedge clk);
      chk(smp_out == hold_ref, "R10", longint'(smp_out[W-1:0]), longint'(hold_ref[W-1:0]));

      // R9: pin in output mode ignores the request, ramp reverses upward
      mute_pin_in = 1'b1;
      for (int k = 0; k < 50; k++) strobe(busy_frame(1000 + k), 1'b1, "R9");
      pin_dir = 1'b1;
      @(negedge clk);
      chk(mute_pin_oe == 1'b1, "R9", mute_pin_oe, 1);
      for (int k = 0; k < 60; k++) strobe(busy_frame(1100 + k), 1'b0, "R9");
      chk(g == 256, "R9", g, 256);
      pin_dir     = 1'b0;
      mute_pin_in = 1'b0;

      // R6, R7: stuck-data run length
      for (int c = 0; c < NCH; c++) flat_f[c*W +: W] = c[0] ? {W{1'b1}} : {W{1'b0}};
      strobe(busy_frame(2000), 1'b0, "R7");
      for (int k = 0; k < LIMIT; k++) strobe(flat_f, 1'b0, "R6");
      chk(mute_flag == 1'b0, "R6", mute_flag, 0);
      strobe(flat_f, 1'b0, "R6");
      chk(mute_flag == 1'b1, "R6", mute_flag, 1);
      for (int k = 0; k < 5; k++) strobe(flat_f, 1'b0, "R6");
      chk(mute_flag == 1'b1, "R6", mute_flag, 1);
      flat_f[2*W +: W] = 24'h000001;
      strobe(flat_f, 1'b0, "R7");
      chk(mute_flag == 1'b0, "R7", mute_flag, 0);

      // R8: fault inputs raise the flag at once
      @(negedge clk);
      clk_fault = 1'b1;
      #1 chk(mute_flag == 1'b1, "R8", mute_flag, 1);
      clk_fault = 1'b0;
      #1 chk(mute_flag == 1'b0, "R8", mute_flag, 0);
      pwr_pending = 1'b1;
      #1 chk(mute_flag == 1'b1, "R8", mute_flag, 1);
      pwr_pending = 1'b0;
      #1 chk(mute_flag == 1'b0, "R8", mute_flag, 0);

      done = 1'b1;
      finish_run();
   end
endmodule